// File: doc/BRIEF.md
# Master Compare Broadcast for an Eight-Channel Output Compare Array

This block sits behind the eight output-compare channels of a timer. Each channel reports its own compare event as a one-cycle fire strobe and a two-bit action code, and the block turns these into the channel's output pin level. Channel 7, the highest channel, is the master. When its comparator reports a match, every channel whose bit is set in a broadcast mask drives its pin to the matching bit of a broadcast data byte. All of these pins change on the same clock edge, and the broadcast takes priority over any action the channel itself fires in that cycle. Channels outside the mask keep their own compare behaviour.

The master match input is a level. Behind a prescaler the counter can hold the compare value for several clocks. A two-state sequencer picks out the first cycle of each match as the hit cycle. In the hit cycle the block applies the broadcast once, sets a sticky master flag once, and, when counter reset on match is enabled, sends a one-cycle counter-reset request to the timer base.

Sequencer states: `SEQ_IDLE` means the master match is low. `SEQ_HELD` means a match has been seen and is still asserted. Transitions: `SEQ_IDLE -> SEQ_HELD` when the match is high, which is the hit cycle. `SEQ_HELD -> SEQ_IDLE` when the match drops. Each state stays put otherwise.

Top module: `mcb_broadcast`

## Requirements
- R1: While `rst_n` is low, and after its release until the next event, `pin_out` is 0, `master_flag` is 0 and `cnt_rst_req` is 0.
- R2: When `own_fire[i]` is high, the action code `own_act[2i+1:2i]` updates pin i at the next clock edge: 2'b00 keeps the pin, 2'b01 inverts it, 2'b10 drives it 0 and 2'b11 drives it 1. A pin with no fire and no broadcast keeps its level.
- R3: In a hit cycle (master match high while the sequencer is in `SEQ_IDLE`), every pin i with `bc_mask[i]`=1 takes `bc_data[i]` at the next edge, whatever its own fire and action are.
- R4: A pin with `bc_mask[i]`=0 is not changed by a hit. It follows only its own R2 action.
- R5: A master match held high for several cycles gives one hit only. In the cycles after the first, masked pins follow their own actions again. A new hit needs the match to go low and then high.
- R6: `master_flag` becomes 1 at the edge that closes a hit cycle and stays 1 until `flag_clr` is sampled high in a cycle that is not a hit cycle. A hit in the same cycle as a clear leaves the flag at 1.
- R7: `cnt_rst_req` is high for exactly the one cycle after a hit cycle in which `rst_on_match` was 1. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_fire | input | NCH | Per-channel compare event strobe |
| own_act | input | 2*NCH | Per-channel action code, channel i in bits [2i+1:2i] |
| master_match | input | 1 | Master channel compare match level |
| bc_mask | input | NCH | Channels that take part in the broadcast |
| bc_data | input | NCH | Level each masked pin takes on a hit |
| rst_on_match | input | 1 | Request a counter reset on a hit |
| flag_clr | input | 1 | Clear the master flag |
| pin_out | output | NCH | Channel output pins |
| master_flag | output | 1 | Sticky master match flag |
| cnt_rst_req | output | 1 | One-cycle counter-reset request |

## Verification
The assertions expect the mask, data and action inputs to hold valid 0/1 values at every sampled edge, and they expect each fire strobe to come from a compare event already qualified by its channel. They place no limit on how long the master match stays high, so the random stimulus holds it for lengths from one to several cycles and also applies it back to back. Mask, data, fire, action and clear are all drawn at random on every cycle, which makes a broadcast collide with a channel's own fire and a flag clear collide with a hit. Directed cases pin down the full mask, the empty mask and the held match.

// File: rtl/mcb_pkg.sv
package mcb_pkg;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_FLIP = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } pin_act_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HELD = 1'b1
    } seq_state_e;

endpackage

// File: rtl/mcb_seq.sv
module mcb_seq
    import mcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    output logic       hit,
    output seq_state_e state_o
);

    seq_state_e state_q;
    seq_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (match)  state_d = SEQ_HELD;
            SEQ_HELD: if (!match) state_d = SEQ_IDLE;
            default:              state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            SEQ_IDLE: hit = match;
            SEQ_HELD: hit = 1'b0;
            default:  hit = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/mcb_pin_cell.sv
module mcb_pin_cell
    import mcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic [1:0] act,
    input  logic       take_bc,
    input  logic       bc_level,
    output logic       pin
);

    logic     pin_d;
    pin_act_e act_e;

    assign act_e = pin_act_e'(act);

    always_comb begin
        pin_d = pin;
        if (take_bc) begin
            pin_d = bc_level;
        end else if (fire) begin
            unique case (act_e)
                ACT_KEEP: pin_d = pin;
                ACT_FLIP: pin_d = ~pin;
                ACT_LOW:  pin_d = 1'b0;
                ACT_HIGH: pin_d = 1'b1;
                default:  pin_d = pin;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pin <= 1'b0;
        else        pin <= pin_d;
    end

endmodule

// File: rtl/mcb_flag.sv
module mcb_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rst_en,
    input  logic clr,
    output logic flag,
    output logic rst_req
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (hit)      flag <= 1'b1;
            else if (clr) flag <= 1'b0;
            rst_req <= hit & rst_en;
        end
    end

endmodule

// File: rtl/mcb_broadcast.sv
module mcb_broadcast
    import mcb_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   own_fire,
    input  logic [2*NCH-1:0] own_act,
    input  logic             master_match,
    input  logic [NCH-1:0]   bc_mask,
    input  logic [NCH-1:0]   bc_data,
    input  logic             rst_on_match,
    input  logic             flag_clr,
    output logic [NCH-1:0]   pin_out,
    output logic             master_flag,
    output logic             cnt_rst_req
);

    logic       hit;
    seq_state_e seq_state;

    mcb_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .match   (master_match),
        .hit     (hit),
        .state_o (seq_state)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        mcb_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .fire     (own_fire[i]),
            .act      (own_act[2*i +: 2]),
            .take_bc  (hit & bc_mask[i]),
            .bc_level (bc_data[i]),
            .pin      (pin_out[i])
        );
    end

    mcb_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .rst_en  (rst_on_match),
        .clr     (flag_clr),
        .flag    (master_flag),
        .rst_req (cnt_rst_req)
    );

endmodule

// File: rtl/mcb_broadcast_chk.sv
module mcb_broadcast_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] own_fire,
    input logic           master_match,
    input logic [NCH-1:0] bc_mask,
    input logic [NCH-1:0] bc_data,
    input logic           rst_on_match,
    input logic           flag_clr,
    input logic [NCH-1:0] pin_out,
    input logic           master_flag,
    input logic           cnt_rst_req,
    input logic           hit
);

    // R3: masked pins take the data byte after a hit
    a_r3_bc_applied: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ((pin_out & $past(bc_mask)) == ($past(bc_data) & $past(bc_mask))));

    // R4: a pin without its own fire and outside a broadcast holds
    a_r4_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(own_fire)
                   & ~($past(bc_mask) & {NCH{$past(hit)}})) == '0));

    // R5: one hit per match
    a_r5_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R5: hit only while the match is high
    a_r5_hit_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> master_match);

    // R6: flag set after a hit
    a_r6_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> master_flag);

    // R6: flag only rises after a hit
    a_r6_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_flag && !hit) |=> !master_flag);

    // R7: reset request follows an enabled hit
    a_r7_rst_req: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && rst_on_match) |=> cnt_rst_req);

    // R7: no reset request otherwise
    a_r7_no_rst_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && rst_on_match) |=> !cnt_rst_req);

endmodule

bind mcb_broadcast mcb_broadcast_chk #(.NCH(NCH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .own_fire     (own_fire),
    .master_match (master_match),
    .bc_mask      (bc_mask),
    .bc_data      (bc_data),
    .rst_on_match (rst_on_match),
    .flag_clr     (flag_clr),
    .pin_out      (pin_out),
    .master_flag  (master_flag),
    .cnt_rst_req  (cnt_rst_req),
    .hit          (hit)
);

// File: tb/mcb_broadcast_bench.sv
module mcb_broadcast_bench;

    localparam int NCH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   own_fire = '0;
    logic [2*NCH-1:0] own_act = '0;
    logic             master_match = 1'b0;
    logic [NCH-1:0]   bc_mask = '0;
    logic [NCH-1:0]   bc_data = '0;
    logic             rst_on_match = 1'b0;
    logic             flag_clr = 1'b0;
    logic [NCH-1:0]   pin_out;
    logic             master_flag;
    logic             cnt_rst_req;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    // model state
    logic [NCH-1:0] m_pins = '0;
    logic           m_held = 1'b0;
    logic           m_flag = 1'b0;
    logic           m_req  = 1'b0;

    always #10 clk = ~clk;

    mcb_broadcast #(.NCH(NCH)) u_mcb_broadcast (
        .clk          (clk),
        .rst_n        (rst_n),
        .own_fire     (own_fire),
        .own_act      (own_act),
        .master_match (master_match),
        .bc_mask      (bc_mask),
        .bc_data      (bc_data),
        .rst_on_match (rst_on_match),
        .flag_clr     (flag_clr),
        .pin_out      (pin_out),
        .master_flag  (master_flag),
        .cnt_rst_req  (cnt_rst_req)
    );

    function automatic logic [NCH-1:0] next_pins(
        input logic [NCH-1:0]   cur,
        input logic             h,
        input logic [NCH-1:0]   msk,
        input logic [NCH-1:0]   dat,
        input logic [NCH-1:0]   fr,
        input logic [2*NCH-1:0] ac);
        logic [NCH-1:0] r;
        r = cur;
        for (int i = 0; i < NCH; i++) begin
            if (h && msk[i]) r[i] = dat[i];
            else if (fr[i]) begin
                case (ac[2*i +: 2])
                    2'b01:   r[i] = ~cur[i];
                    2'b10:   r[i] = 1'b0;
                    2'b11:   r[i] = 1'b1;
                    default: r[i] = cur[i];
                endcase
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // one clock with the inputs already driven; compare at the next falling edge
    task automatic step();
        logic h;
        string tp;
        h = master_match && !m_held;
        if (h && bc_mask != '0)      tp = "R3/R4 pins";
        else if (master_match)        tp = "R5 pins";
        else                          tp = "R2 pins";
        m_pins = next_pins(m_pins, h, bc_mask, bc_data, own_fire, own_act);
        m_flag = h ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
        m_req  = h && rst_on_match;
        m_held = master_match;
        @(posedge clk);
        @(negedge clk);
        check(tp, pin_out, m_pins);
        check("R6 flag", {7'd0, master_flag}, {7'd0, m_flag});
        check("R7 rst_req", {7'd0, cnt_rst_req}, {7'd0, m_req});
    endtask

    task automatic quiet();
        own_fire = '0; own_act = '0; master_match = 1'b0; flag_clr = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 pins", pin_out, '0);
        check("R1 flag", {7'd0, master_flag}, 8'd0);
        check("R1 rst_req", {7'd0, cnt_rst_req}, 8'd0);
        rst_n = 1'b1;
        step();

        // R2: each action code on its own
        own_fire = 8'hFF; own_act = 16'hFFFF; step();      // all high
        own_act = 16'h5555; step();                         // flip -> 0
        own_act = 16'h5555; own_fire = 8'h0F; step();       // lower nibble flips
        own_act = 16'hAAAA; own_fire = 8'hF0; step();       // upper to 0
        own_act = 16'h0000; own_fire = 8'hFF; step();       // keep
        quiet(); step();

        // R3: full mask broadcast against opposite own actions
        own_fire = 8'hFF; own_act = 16'hFFFF;
        bc_mask = 8'hFF; bc_data = 8'h00; master_match = 1'b1; rst_on_match = 1'b1;
        step();
        // R5: held match, masked pins follow own actions again
        own_act = 16'h5555; step();
        own_act = 16'hFFFF; step();
        quiet(); step();

        // R4: empty mask, own flips still work, flag set, no reset request
        bc_mask = 8'h00; bc_data = 8'hFF; rst_on_match = 1'b0;
        master_match = 1'b1; own_fire = 8'h81; own_act = 16'h4001; step();
        quiet(); step();

        // R6: clear alone, then clear together with a hit
        flag_clr = 1'b1; step();
        bc_mask = 8'h3C; bc_data = 8'hA5; master_match = 1'b1; step();
        quiet(); step();

        // random mix
        for (int n = 0; n < 4000; n++) begin
            own_fire     = NCH'($urandom);
            own_act      = (2*NCH)'($urandom);
            bc_mask      = NCH'($urandom);
            bc_data      = NCH'($urandom);
            rst_on_match = 1'($urandom);
            flag_clr     = ($urandom % 5) == 0;
            if (($urandom % 3) == 0) master_match = ~master_match;
            step();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule